// File: doc/BRIEF.md
# Key-Protected Clock Select Controller

This block is the clock-system controller of a small microcontroller. It sits on a plain register bus with an address, write data, a write strobe and combinational read data. Three derived clocks come out of it: a main clock for the processor, a subsystem clock for fast peripherals, and an auxiliary clock for slow peripherals. For each derived clock the controller picks one incoming source, divides it by a selectable power of two, and emits a single-cycle tick for every divided period. It also drives on/off controls for two crystal oscillators and carries the range and frequency settings of the digitally controlled oscillator.

All sources are modelled as level inputs sampled in the system clock domain. Each rising edge that is sampled counts as one source period. The controller accepts configuration only after software writes a key value to the lock register. Any other value written there locks it again. The auxiliary clock is restricted to low-frequency sources, and one of these is the module oscillator divided by 128 internally.

Top module: `cksys_ctrl`

## Requirements
- R1: While locked, bus writes to addresses 1 to 4 leave every register unchanged. After reset the controller is locked.
- R2: Writing 0xA55A to address 0 unlocks the controller, and writing any other value to address 0 locks it. Reading address 0 always returns 0x9600.
- R3: After reset the registers read as follows. Address 2 reads 0x0330: auxiliary select 0, main select 3, subsystem select 3. Address 3 reads 0x0000. Address 4 reads 0x0001: low-frequency crystal on, high-frequency crystal off. Address 1 reads 0x0000. All tick outputs are low.
- R4: The address 2 fields are auxiliary [2:0], main [6:4] and subsystem [10:8]. For main and subsystem, code 0 selects the low-frequency crystal, 1 the very-low-power oscillator, 2 the module oscillator, 3 the digitally controlled oscillator and 4 the high-frequency crystal. A derived clock ticks only on edges of its selected source.
- R5: For the auxiliary clock, code 0 selects the low-frequency crystal, 1 the very-low-power oscillator, and 2 the module oscillator divided by 128. With divide-by-1, code 2 gives one tick per 128 module-oscillator edges, counted from reset.
- R6: A select code that is not allowed for a clock (5 to 7 for main and subsystem, 3 to 7 for auxiliary) leaves that clock's field unchanged. Valid fields in the same write still update.
- R7: The address 3 fields use the same positions as address 2. Divider code n from 0 to 5 divides by 2^n, and codes 6 and 7 divide by 32.
- R8: A new divider code takes effect only when the old division reaches its terminal count. The tick at that terminal count is the last one produced under the old code.
- R9: Address 4 bit 0 switches the low-frequency crystal on and bit 1 switches the high-frequency crystal on. These bits drive `lfxt_en` and `hfxt_en`. A derived clock whose selected crystal is off produces no ticks.
- R10: Each tick output is high for exactly one system clock cycle at a time.
- R11: Address 1 bits [2:0] drive `dco_freq` and bit 4 drives `dco_range`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| src_lfxt | input | 1 | Low-frequency crystal source level |
| src_vlo | input | 1 | Very-low-power oscillator level |
| src_mod | input | 1 | Module oscillator level |
| src_dco | input | 1 | Digitally controlled oscillator level |
| src_hfxt | input | 1 | High-frequency crystal source level |
| main_tick | output | 1 | Main clock tick |
| sub_tick | output | 1 | Subsystem clock tick |
| aux_tick | output | 1 | Auxiliary clock tick |
| lfxt_en | output | 1 | Low-frequency crystal enable |
| hfxt_en | output | 1 | High-frequency crystal enable |
| dco_range | output | 1 | Oscillator range select |
| dco_freq | output | 3 | Oscillator frequency select |

## Verification
Register state is readable on the bus, so a wrong lock state, a wrong stored field or a wrong invalid-code filter shows up on the first read after the write. A wrong active divider or a wrong count does not show until the next source edges. The fault appears as a missing or extra tick within at most 32 edges of the selected source. A fault in the 128 prescaler needs 128 module-oscillator edges before the first auxiliary tick is late or early. The scenarios therefore drive a full 256 edges.

// File: rtl/cksys_pkg.sv
package cksys_pkg;
   // physical source indices, shared by source stage and channels
   localparam int SRC_LFXT  = 0;
   localparam int SRC_VLO   = 1;
   localparam int SRC_MOD   = 2;
   localparam int SRC_DCO   = 3;
   localparam int SRC_HFXT  = 4;
   localparam int SRC_LFMOD = 5;
   localparam int NSRC      = 6;
   localparam int NSRC_IN   = 5;

   // register addresses
   localparam int A_LOCK = 0;
   localparam int A_DCO  = 1;
   localparam int A_SEL  = 2;
   localparam int A_DIV  = 3;
   localparam int A_OSC  = 4;

   // channel indices and field offsets inside select/divider registers
   localparam int CH_MAIN = 0;
   localparam int CH_SUB  = 1;
   localparam int CH_AUX  = 2;
   localparam int NCH     = 3;

   function automatic int field_lo(input int ch);
      return (ch == CH_AUX) ? 0 : (ch == CH_MAIN) ? 4 : 8;
   endfunction
endpackage

// File: rtl/cksys_regs.sv
module cksys_regs
   import cksys_pkg::*;
#(
   parameter int            DW      = 16,
   parameter int            AW      = 3,
   parameter int            SW      = 3,
   parameter logic [DW-1:0] KEY     = 16'hA55A,
   parameter logic [DW-1:0] LOCK_RD = 16'h9600
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AW-1:0]          addr,
   input  logic [DW-1:0]          wdata,
   input  logic                   we,
   output logic [DW-1:0]          rdata,
   output logic [NCH-1:0][SW-1:0] sel_f,
   output logic [NCH-1:0][SW-1:0] div_f,
   output logic                   lfxt_on,
   output logic                   hfxt_on,
   output logic                   dco_rsel,
   output logic [2:0]             dco_fsel
);
   localparam int MS_MAX  = SRC_HFXT;
   localparam int AUX_MAX = 2;

   initial assert (DW >= 12 && SW == 3) else $fatal(1, "cksys_regs: field layout needs DW>=12, SW==3");

   logic unlocked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unlocked         <= 1'b0;
         sel_f[CH_MAIN]   <= SW'(SRC_DCO);
         sel_f[CH_SUB]    <= SW'(SRC_DCO);
         sel_f[CH_AUX]    <= '0;
         div_f            <= '0;
         lfxt_on          <= 1'b1;
         hfxt_on          <= 1'b0;
         dco_rsel         <= 1'b0;
         dco_fsel         <= '0;
      end else if (we) begin
         if (addr == AW'(A_LOCK)) begin
            unlocked <= (wdata == KEY);
         end else if (unlocked) begin
            case (addr)
               AW'(A_DCO): begin
                  dco_fsel <= wdata[2:0];
                  dco_rsel <= wdata[4];
               end
               AW'(A_SEL): begin
                  for (int c = 0; c < NCH; c++) begin
                     if (int'(wdata[field_lo(c) +: SW]) <= ((c == CH_AUX) ? AUX_MAX : MS_MAX))
                        sel_f[c] <= wdata[field_lo(c) +: SW];
                  end
               end
               AW'(A_DIV): begin
                  for (int c = 0; c < NCH; c++)
                     div_f[c] <= wdata[field_lo(c) +: SW];
               end
               AW'(A_OSC): begin
                  lfxt_on <= wdata[0];
                  hfxt_on <= wdata[1];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         AW'(A_LOCK): rdata = LOCK_RD;
         AW'(A_DCO):  rdata[4:0] = {dco_rsel, 1'b0, dco_fsel};
         AW'(A_SEL):  for (int c = 0; c < NCH; c++) rdata[field_lo(c) +: SW] = sel_f[c];
         AW'(A_DIV):  for (int c = 0; c < NCH; c++) rdata[field_lo(c) +: SW] = div_f[c];
         AW'(A_OSC):  rdata[1:0] = {hfxt_on, lfxt_on};
         default:     rdata = '0;
      endcase
   end

   // R1: locked writes leave every configuration register unchanged
   p_locked_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !unlocked && addr != AW'(A_LOCK)) |=>
         ($stable(sel_f) && $stable(div_f) && $stable({lfxt_on, hfxt_on, dco_rsel, dco_fsel})));

   // R2: a non-key write to the lock register re-locks
   p_relock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == AW'(A_LOCK) && wdata != KEY) |=> !unlocked);

   // R6: an illegal main select code keeps the stored main field
   p_bad_main_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == AW'(A_SEL) && int'(wdata[6:4]) > MS_MAX) |=> $stable(sel_f[CH_MAIN]));
endmodule

// File: rtl/cksys_srcs.sv
module cksys_srcs
   import cksys_pkg::*;
#(
   parameter int LFMOD_DIV = 128
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NSRC_IN-1:0] src_lvl,
   input  logic               lfxt_on,
   input  logic               hfxt_on,
   output logic [NSRC-1:0]    tick,
   output logic [NSRC-1:0]    ok
);
   localparam int PRE_W = $clog2(LFMOD_DIV);

   initial assert (LFMOD_DIV >= 2) else $fatal(1, "cksys_srcs: prescale must be at least 2");

   logic [NSRC_IN-1:0] lvl_q;
   logic [NSRC_IN-1:0] rise;
   logic [PRE_W-1:0]   pcnt;
   logic               pre_term;

   assign rise     = src_lvl & ~lvl_q;
   assign pre_term = (pcnt == PRE_W'(LFMOD_DIV - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= '0;
         pcnt  <= '0;
      end else begin
         lvl_q <= src_lvl;
         if (rise[SRC_MOD]) pcnt <= pre_term ? '0 : pcnt + 1'b1;
      end
   end

   always_comb begin
      tick             = '0;
      tick[NSRC_IN-1:0] = rise;
      tick[SRC_LFMOD]  = rise[SRC_MOD] && pre_term;
      ok               = '1;
      ok[SRC_LFXT]     = lfxt_on;
      ok[SRC_HFXT]     = hfxt_on;
   end

   // R5: the divided module-oscillator tick only coincides with a module edge
   p_lfmod_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick[SRC_LFMOD] |-> tick[SRC_MOD]);
endmodule

// File: rtl/cksys_chan.sv
module cksys_chan
   import cksys_pkg::*;
#(
   parameter bit IS_AUX    = 1'b0,
   parameter int SW        = 3,
   parameter int DIV_CODES = 6
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SW-1:0]   sel,
   input  logic [SW-1:0]   div,
   input  logic [NSRC-1:0] tick,
   input  logic [NSRC-1:0] ok,
   output logic            pulse
);
   localparam int CNT_W = DIV_CODES - 1;

   initial assert (DIV_CODES >= 2 && DIV_CODES <= (1 << SW))
      else $fatal(1, "cksys_chan: divider codes do not fit select width");

   logic [2:0]       phys;
   logic             sel_tick;
   logic             sel_ok;
   logic [SW-1:0]    act_div;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;
   logic             term;

   if (IS_AUX) begin : g_aux_map
      always_comb begin
         case (sel)
            SW'(0):  phys = 3'(SRC_LFXT);
            SW'(1):  phys = 3'(SRC_VLO);
            default: phys = 3'(SRC_LFMOD);
         endcase
      end
   end else begin : g_full_map
      always_comb phys = (int'(sel) > SRC_HFXT) ? 3'(SRC_DCO) : 3'(sel);
   end

   assign sel_ok   = ok[phys];
   assign sel_tick = tick[phys] && sel_ok;
   assign lim      = (int'(act_div) >= DIV_CODES - 1) ? '1 : CNT_W'((32'd1 << act_div) - 32'd1);
   assign term     = (cnt >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         act_div <= '0;
         pulse   <= 1'b0;
      end else begin
         pulse <= sel_tick && term;
         if (sel_tick) begin
            if (term) begin
               cnt     <= '0;
               act_div <= div;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R8: the active divider only moves at a terminal count
   p_div_at_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_tick && term) |=> $stable(act_div));

   // R9: a switched-off source yields no tick next cycle
   p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ok |=> !pulse);

   // R10: ticks last one cycle
   p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/cksys_ctrl.sv
module cksys_ctrl
   import cksys_pkg::*;
#(
   parameter int            DW        = 16,
   parameter int            AW        = 3,
   parameter logic [DW-1:0] KEY       = 16'hA55A,
   parameter logic [DW-1:0] LOCK_RD   = 16'h9600,
   parameter int            LFMOD_DIV = 128,
   parameter int            DIV_CODES = 6
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_we,
   output logic [DW-1:0] bus_rdata,
   input  logic          src_lfxt,
   input  logic          src_vlo,
   input  logic          src_mod,
   input  logic          src_dco,
   input  logic          src_hfxt,
   output logic          main_tick,
   output logic          sub_tick,
   output logic          aux_tick,
   output logic          lfxt_en,
   output logic          hfxt_en,
   output logic          dco_range,
   output logic [2:0]    dco_freq
);
   localparam int SW = 3;

   logic [NCH-1:0][SW-1:0] sel_f;
   logic [NCH-1:0][SW-1:0] div_f;
   logic [NSRC-1:0]        tick;
   logic [NSRC-1:0]        ok;
   logic [NCH-1:0]         pulses;

   cksys_regs #(.DW(DW), .AW(AW), .SW(SW), .KEY(KEY), .LOCK_RD(LOCK_RD)) i_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
      .rdata(bus_rdata), .sel_f(sel_f), .div_f(div_f), .lfxt_on(lfxt_en),
      .hfxt_on(hfxt_en), .dco_rsel(dco_range), .dco_fsel(dco_freq)
   );

   cksys_srcs #(.LFMOD_DIV(LFMOD_DIV)) i_srcs (
      .clk(clk), .rst_n(rst_n),
      .src_lvl({src_hfxt, src_dco, src_mod, src_vlo, src_lfxt}),
      .lfxt_on(lfxt_en), .hfxt_on(hfxt_en), .tick(tick), .ok(ok)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      cksys_chan #(.IS_AUX(c == CH_AUX), .SW(SW), .DIV_CODES(DIV_CODES)) i_chan (
         .clk(clk), .rst_n(rst_n), .sel(sel_f[c]), .div(div_f[c]),
         .tick(tick), .ok(ok), .pulse(pulses[c])
      );
   end

   assign main_tick = pulses[CH_MAIN];
   assign sub_tick  = pulses[CH_SUB];
   assign aux_tick  = pulses[CH_AUX];
endmodule

// File: tb/test_cksys_ctrl.sv
`timescale 1ns/1ps
module test_cksys_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_rdata;
   logic [4:0]  src = '0;
   logic        main_tick, sub_tick, aux_tick, lfxt_en, hfxt_en, dco_range;
   logic [2:0]  dco_freq;

   int n_run = 0, n_fail = 0;
   int cm = 0, cs = 0, ca = 0, doubles = 0;
   logic pm = 0, ps = 0, pa = 0;
   bit   done = 0;

   localparam logic [15:0] KEY = 16'hA55A;

   cksys_ctrl i_cksys_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata),
      .src_lfxt(src[0]), .src_vlo(src[1]), .src_mod(src[2]), .src_dco(src[3]), .src_hfxt(src[4]),
      .main_tick(main_tick), .sub_tick(sub_tick), .aux_tick(aux_tick),
      .lfxt_en(lfxt_en), .hfxt_en(hfxt_en), .dco_range(dco_range), .dco_freq(dco_freq)
   );

   always #4 clk = ~clk;

   // tick counters and one-cycle monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (main_tick) cm++;
         if (sub_tick)  cs++;
         if (aux_tick)  ca++;
         if ((main_tick && pm) || (sub_tick && ps) || (aux_tick && pa)) doubles++;
      end
      pm = main_tick; ps = sub_tick; pa = aux_tick;
   end

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; src = '0; bus_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr = 3'(a); bus_wdata = 16'(d); bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      bus_addr = 3'(a);
      #1 d = int'(bus_rdata);
   endtask

   task automatic pulses(input int idx, input int n);
      @(negedge clk);
      cm = 0; cs = 0; ca = 0;
      for (int i = 0; i < n; i++) begin
         src[idx] = 1'b1;
         @(negedge clk);
         src[idx] = 1'b0;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      int v;
      do_reset();
      rd(2, v); check("R3 select reset", v, 16'h0330);
      rd(3, v); check("R3 divider reset", v, 0);
      rd(4, v); check("R3 oscillator reset", v, 1);
      rd(1, v); check("R3 dco reset", v, 0);
      check("R3 ticks low", {main_tick, sub_tick, aux_tick}, 0);
      check("R9 enables after reset", {hfxt_en, lfxt_en}, 1);
      rd(0, v); check("R2 lock readback", v, 16'h9600);
   endtask

   task automatic t_lock();
      int v;
      do_reset();
      wr(2, 16'h0000);
      rd(2, v); check("R1 locked select write ignored", v, 16'h0330);
      wr(4, 16'h0003);
      rd(4, v); check("R1 locked osc write ignored", v, 1);
      wr(0, KEY);
      wr(2, 16'h0100);
      rd(2, v); check("R2 unlocked write applied", v, 16'h0100);
      rd(0, v); check("R2 lock reads fixed when open", v, 16'h9600);
      wr(0, 16'h1234);
      wr(2, 16'h0330);
      rd(2, v); check("R2 relocked write ignored", v, 16'h0100);
   endtask

   task automatic t_main_sub();
      do_reset();
      wr(0, KEY);
      wr(4, 16'h0003);
      for (int c = 0; c < 5; c++) begin
         wr(2, (c << 4) | (((c + 1) % 5) << 8));
         pulses(c, 4);
         check($sformatf("R4 main code %0d", c), cm, 4);
         check($sformatf("R4 sub ignores code %0d source", c), cs, 0);
         pulses((c + 1) % 5, 3);
         check($sformatf("R4 sub code %0d", (c + 1) % 5), cs, 3);
         check($sformatf("R4 main ignores other source %0d", c), cm, 0);
      end
   endtask

   task automatic t_aux();
      do_reset();
      pulses(0, 3);
      check("R5 aux low-freq crystal", ca, 3);
      wr(0, KEY);
      wr(2, 16'h0331);
      pulses(1, 3);
      check("R5 aux vlo", ca, 3);
      wr(2, 16'h0332);
      pulses(1, 3);
      check("R5 aux ignores vlo when on divided module", ca, 0);
      pulses(2, 256);
      check("R5 aux module/128", ca, 2);
   endtask

   task automatic t_invalid();
      int v;
      do_reset();
      wr(0, KEY);
      wr(2, 16'h0253);
      rd(2, v); check("R6 illegal aux/main kept, sub updated", v, 16'h0230);
      wr(2, 16'h0742);
      rd(2, v); check("R6 illegal sub kept", v, 16'h0242);
   endtask

   task automatic t_div();
      for (int code = 0; code < 8; code++) begin
         int d;
         d = (code >= 5) ? 32 : (1 << code);
         do_reset();
         wr(0, KEY);
         wr(3, code << 4);
         pulses(3, 40);
         check($sformatf("R7 divider code %0d", code), cm, 1 + (39 / d));
      end
   endtask

   task automatic t_div_change();
      do_reset();
      wr(0, KEY);
      wr(3, 16'h0020);
      pulses(3, 1); check("R8 first tick loads /4", cm, 1);
      pulses(3, 2); check("R8 /4 mid count", cm, 0);
      wr(3, 16'h0000);
      pulses(3, 1); check("R8 old /4 still active", cm, 0);
      pulses(3, 1); check("R8 terminal tick under /4", cm, 1);
      pulses(3, 3); check("R8 /1 after terminal", cm, 3);
   endtask

   task automatic t_xtal();
      do_reset();
      wr(0, KEY);
      wr(2, 16'h0300);
      wr(4, 0);
      check("R9 lfxt_en off", lfxt_en, 0);
      pulses(0, 4); check("R9 lfxt off no ticks", cm, 0);
      wr(4, 1);
      pulses(0, 4); check("R9 lfxt back on", cm, 4);
      wr(2, 16'h0340);
      pulses(4, 4); check("R9 hfxt off by default", cm, 0);
      wr(4, 2);
      check("R9 hfxt_en on", hfxt_en, 1);
      pulses(4, 4); check("R9 hfxt on", cm, 4);
   endtask

   task automatic t_dco();
      int v;
      do_reset();
      wr(0, KEY);
      wr(1, 16'h0015);
      rd(1, v); check("R11 dco readback", v, 16'h0015);
      check("R11 dco_freq", dco_freq, 5);
      check("R11 dco_range", dco_range, 1);
   endtask

   initial begin
      t_reset();
      t_lock();
      t_main_sub();
      t_aux();
      t_invalid();
      t_div();
      t_div_change();
      t_xtal();
      t_dco();
      check("R10 no multi-cycle ticks", doubles, 0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule